// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block is the multi-cycle engine an 8-bit CPU core calls when it executes its software-interrupt opcode (0x83). The core supplies its program counter, stack pointer, index byte, accumulator and condition-code byte and pulses a start strobe. The sequencer first advances the program counter by one so that the saved return address points past the one-byte instruction. It then pushes the return context onto a byte stack that grows toward lower addresses, sets the interrupt-mask bit, and reads a fresh program counter from a two-byte vector at a fixed address. It does all of this over a simple byte-wide memory port.

The sequence always occupies eleven clock cycles. Each cycle carries at most one memory access, and the internal cycles drive no strobe. The states, in order, are: `ST_IDLE` (waiting; it leaves on start), `ST_BUMP` (adds one to the PC), `ST_PUSH_PCL`, `ST_PUSH_PCH`, `ST_PUSH_X`, `ST_PUSH_A`, `ST_PUSH_CCR` (one stack write each), `ST_MASK` (sets the mask bit), `ST_FETCH_HI` and `ST_FETCH_LO` (vector reads), `ST_LOAD` (takes the low vector byte) and `ST_DONE` (raises done, then returns to `ST_IDLE`). Every non-idle state moves to the next one unconditionally. A synchronous reset sends any state back to `ST_IDLE`.

Top module: `swi_stacker`

## Requirements
- R1: When start is high at a rising edge in idle, the sequence begins. done is high in the cycle that follows the tenth rising edge after that edge, so the sequence spans 11 cycles.
- R2: The return address is pc_in+1, modulo 2^16. Its low byte is written in the first write cycle and its high byte in the second.
- R3: The five writes go to sp_in, sp_in-1, sp_in-2, sp_in-3 and sp_in-4, in the order PC low, PC high, X, A, CCR. sp_out ends at sp_in-5. All SP arithmetic wraps modulo 2^16.
- R4: The stacked CCR byte equals ccr_in. When done is high, ccr_out equals ccr_in with bit IBIT (default 3) forced to 1, and every other bit is unchanged.
- R5: At most one of mem_we and mem_re is high in any cycle. A full sequence issues exactly 5 writes and 2 reads. The bump, mask, load and done cycles drive no strobe.
- R6: The reads go first to VEC and then to VEC+1. Read data returns in the cycle after the strobe. When done is high, pc_out equals {byte at VEC, byte at VEC+1}.
- R7: A start strobe that arrives while the sequence is running is ignored. It neither restarts nor extends the sequence.
- R8: done is high for exactly one clock per sequence.
- R9: A synchronous reset returns the block to idle with no strobes and no done. It leaves pc_out, sp_out and ccr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the entry sequence (sampled in idle) |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| x_in | input | 8 | Current index byte |
| a_in | input | 8 | Current accumulator |
| ccr_in | input | 8 | Current condition-code byte |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 16 | Updated stack pointer |
| ccr_out | output | 8 | Updated condition-code byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions on every cycle. The two strobes are never high together. SP drops by one after every write. The mask step sets the I bit and touches no other flag. Reads go only to the two vector addresses. A running sequence advances its state on every cycle. done lasts one clock. Reset leaves the PC register untouched. Other behaviour can only be shown by the bench scenarios. These are the exact byte order and addresses of the pushes, the incremented return address, and the wrap of PC and SP across zero. They also cover the loaded vector value, the eleven-cycle latency, a start pulse that arrives mid-sequence, and a reset that cuts a sequence short.

// File: rtl/swi_pkg.sv
package swi_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUMP,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_X,
        ST_PUSH_A,
        ST_PUSH_CCR,
        ST_MASK,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_LOAD,
        ST_DONE
    } swi_state_e;
endpackage

// File: rtl/swi_fsm.sv
module swi_fsm
    import swi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output swi_state_e state,
    output logic       launch
);
    swi_state_e nxt;

    assign launch = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = start ? ST_BUMP : ST_IDLE;
            ST_BUMP:     nxt = ST_PUSH_PCL;
            ST_PUSH_PCL: nxt = ST_PUSH_PCH;
            ST_PUSH_PCH: nxt = ST_PUSH_X;
            ST_PUSH_X:   nxt = ST_PUSH_A;
            ST_PUSH_A:   nxt = ST_PUSH_CCR;
            ST_PUSH_CCR: nxt = ST_MASK;
            ST_MASK:     nxt = ST_FETCH_HI;
            ST_FETCH_HI: nxt = ST_FETCH_LO;
            ST_FETCH_LO: nxt = ST_LOAD;
            ST_LOAD:     nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // R7: once running, the state advances every cycle whatever start does
    a_r7_busy_advances: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != $past(state)));
endmodule

// File: rtl/swi_ctx_regs.sv
module swi_ctx_regs
    import swi_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int IBIT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  swi_state_e    state,
    input  logic          launch,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] ccr_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc_r,
    output logic [AW-1:0] sp_r,
    output logic [DW-1:0] x_r,
    output logic [DW-1:0] a_r,
    output logic [DW-1:0] ccr_r
);
    localparam logic [DW-1:0] MASK_BIT = DW'(1) << IBIT;
    localparam int            HB       = AW - DW;

    logic [HB-1:0] vec_hi;
    logic          pushing;

    assign pushing = (state == ST_PUSH_PCL) || (state == ST_PUSH_PCH) ||
                     (state == ST_PUSH_X)   || (state == ST_PUSH_A)   ||
                     (state == ST_PUSH_CCR);

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (launch) begin
                pc_r  <= pc_in;
                sp_r  <= sp_in;
                x_r   <= x_in;
                a_r   <= a_in;
                ccr_r <= ccr_in;
            end
            if (state == ST_BUMP)     pc_r   <= pc_r + AW'(1);
            if (pushing)              sp_r   <= sp_r - AW'(1);
            if (state == ST_MASK)     ccr_r  <= ccr_r | MASK_BIT;
            if (state == ST_FETCH_LO) vec_hi <= HB'(mem_rdata);
            if (state == ST_LOAD)     pc_r   <= {vec_hi, mem_rdata};
        end
    end

    // R3: every stack write is followed by a one-step decrement
    a_r3_sp_steps_down: assert property (@(posedge clk) disable iff (rst)
        pushing |=> (sp_r == $past(sp_r) - AW'(1)));
    // R4: mask step sets the I bit and leaves the other flags alone
    a_r4_mask_only_ibit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MASK) |=> (ccr_r[IBIT] && ((ccr_r | MASK_BIT) == ($past(ccr_r) | MASK_BIT))));
    // R9: reset never alters the PC register
    a_r9_reset_keeps_pc: assert property (@(posedge clk)
        (rst && $past(rst)) |-> $stable(pc_r));
endmodule

// File: rtl/swi_bus_drv.sv
module swi_bus_drv
    import swi_pkg::*;
#(
    parameter int            AW  = 16,
    parameter int            DW  = 8,
    parameter logic [AW-1:0] VEC = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst,
    input  swi_state_e    state,
    input  logic [AW-1:0] pc_r,
    input  logic [AW-1:0] sp_r,
    input  logic [DW-1:0] x_r,
    input  logic [DW-1:0] a_r,
    input  logic [DW-1:0] ccr_r,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic          done
);
    localparam logic [AW-1:0] VEC_LO = VEC + AW'(1);

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_PUSH_PCL: begin mem_we = 1'b1; mem_addr = sp_r; mem_wdata = pc_r[DW-1:0]; end
            ST_PUSH_PCH: begin mem_we = 1'b1; mem_addr = sp_r; mem_wdata = DW'(pc_r >> DW); end
            ST_PUSH_X:   begin mem_we = 1'b1; mem_addr = sp_r; mem_wdata = x_r; end
            ST_PUSH_A:   begin mem_we = 1'b1; mem_addr = sp_r; mem_wdata = a_r; end
            ST_PUSH_CCR: begin mem_we = 1'b1; mem_addr = sp_r; mem_wdata = ccr_r; end
            ST_FETCH_HI: begin mem_re = 1'b1; mem_addr = VEC; end
            ST_FETCH_LO: begin mem_re = 1'b1; mem_addr = VEC_LO; end
            ST_DONE:     done = 1'b1;
            default: ;
        endcase
    end

    // R5: never a read and a write in the same cycle
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    // R6: reads target only the vector pair
    a_r6_vector_addr: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> ((mem_addr == VEC) || (mem_addr == VEC_LO)));
    // R8: done never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/swi_stacker.sv
module swi_stacker
    import swi_pkg::*;
#(
    parameter int            AW   = 16,
    parameter int            DW   = 8,
    parameter int            IBIT = 3,
    parameter logic [AW-1:0] VEC  = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] ccr_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out,
    output logic [DW-1:0] ccr_out,
    output logic          done
);
    swi_state_e    state;
    logic          launch;
    logic [DW-1:0] x_r, a_r;

    swi_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .state(state), .launch(launch)
    );

    swi_ctx_regs #(.AW(AW), .DW(DW), .IBIT(IBIT)) u_regs (
        .clk(clk), .rst(rst), .state(state), .launch(launch),
        .pc_in(pc_in), .sp_in(sp_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata),
        .pc_r(pc_out), .sp_r(sp_out), .x_r(x_r), .a_r(a_r), .ccr_r(ccr_out)
    );

    swi_bus_drv #(.AW(AW), .DW(DW), .VEC(VEC)) u_bus (
        .clk(clk), .rst(rst), .state(state),
        .pc_r(pc_out), .sp_r(sp_out), .x_r(x_r), .a_r(a_r), .ccr_r(ccr_out),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .done(done)
    );
endmodule

// File: tb/swi_stacker_test.sv
module swi_stacker_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] VEC        = 16'hFFFC;
    localparam int          IBIT       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, ccr_out;
    logic        mem_we, mem_re, done;
    logic [7:0]  vec_h = '0, vec_l = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    swi_stacker #(.VEC(VEC), .IBIT(IBIT)) uut (
        .clk(clk), .rst(rst), .start(start),
        .pc_in(pc_in), .sp_in(sp_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re),
        .pc_out(pc_out), .sp_out(sp_out), .ccr_out(ccr_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench memory: vector pair only, one-cycle read latency
    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= (mem_addr == VEC) ? vec_h :
                         (mem_addr == VEC + 16'd1) ? vec_l : 8'hEE;
    end

    function automatic logic [15:0] exp_ret(input logic [15:0] pc);
        return pc + 16'd1;
    endfunction

    function automatic logic [7:0] exp_ccr(input logic [7:0] c);
        return c | (8'd1 << IBIT);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one full sequence; busy_pulse drives start again mid-run (R7)
    task automatic run_seq(input logic [15:0] pc, input logic [15:0] sp,
                           input logic [7:0] x, input logic [7:0] a,
                           input logic [7:0] c, input logic [7:0] vh,
                           input logic [7:0] vl, input bit busy_pulse);
        logic [15:0] wa[5];
        logic [7:0]  wd[5];
        logic [15:0] ra[2];
        logic [15:0] ret;
        int nw, nr, ndone, done_at, both;
        nw = 0; nr = 0; ndone = 0; done_at = -1; both = 0;
        @(negedge clk);
        pc_in = pc; sp_in = sp; x_in = x; a_in = a; ccr_in = c;
        vec_h = vh; vec_l = vl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 24; i++) begin
            if (busy_pulse && (i == 3 || i == 4 || i == 9)) start = 1'b1;
            else start = 1'b0;
            if (mem_we && mem_re) both++;
            if (mem_we) begin
                if (nw < 5) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
                nw++;
            end
            if (mem_re) begin
                if (nr < 2) ra[nr] = mem_addr;
                nr++;
            end
            if (done) begin
                ndone++;
                if (done_at < 0) begin
                    done_at = i;
                    chk(pc_out == {vh, vl}, "R6 pc_out", 32'(pc_out), 32'({vh, vl}));
                    chk(sp_out == sp - 16'd5, "R3 sp_out", 32'(sp_out), 32'(sp - 16'd5));
                    chk(ccr_out == exp_ccr(c), "R4 ccr_out", 32'(ccr_out), 32'(exp_ccr(c)));
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        ret = exp_ret(pc);
        chk(done_at == 10, "R1 latency", 32'(done_at), 32'd10);
        chk(ndone == 1, "R8 single done", 32'(ndone), 32'd1);
        chk(ndone == 1, "R7 busy start ignored", 32'(ndone), 32'd1);
        chk(both == 0, "R5 exclusive strobes", 32'(both), 32'd0);
        chk(nw == 5, "R5 write count", 32'(nw), 32'd5);
        chk(nr == 2, "R5 read count", 32'(nr), 32'd2);
        if (nw >= 5) begin
            for (int k = 0; k < 5; k++)
                chk(wa[k] == sp - 16'(k), "R3 push addr", 32'(wa[k]), 32'(sp - 16'(k)));
            chk(wd[0] == ret[7:0],  "R2 pc low pushed first", 32'(wd[0]), 32'(ret[7:0]));
            chk(wd[1] == ret[15:8], "R2 pc high pushed second", 32'(wd[1]), 32'(ret[15:8]));
            chk(wd[2] == x, "R3 x pushed", 32'(wd[2]), 32'(x));
            chk(wd[3] == a, "R3 a pushed", 32'(wd[3]), 32'(a));
            chk(wd[4] == c, "R4 ccr pushed unmasked", 32'(wd[4]), 32'(c));
        end
        if (nr >= 2) begin
            chk(ra[0] == VEC, "R6 first read", 32'(ra[0]), 32'(VEC));
            chk(ra[1] == VEC + 16'd1, "R6 second read", 32'(ra[1]), 32'(VEC + 16'd1));
        end
    endtask

    task automatic reset_mid_seq();
        logic [15:0] p0, s0;
        logic [7:0]  c0;
        int strobes, dn;
        strobes = 0; dn = 0;
        @(negedge clk);
        pc_in = 16'h1234; sp_in = 16'h0100; x_in = 8'h11; a_in = 8'h22; ccr_in = 8'h40;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        p0 = pc_out; s0 = sp_out; c0 = ccr_out;
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            if (mem_we || mem_re) strobes++;
            if (done) dn++;
        end
        chk(pc_out == p0, "R9 pc held in reset", 32'(pc_out), 32'(p0));
        chk(sp_out == s0, "R9 sp held in reset", 32'(sp_out), 32'(s0));
        chk(ccr_out == c0, "R9 ccr held in reset", 32'(ccr_out), 32'(c0));
        rst = 1'b0;
        repeat (14) begin
            @(negedge clk);
            if (mem_we || mem_re) strobes++;
            if (done) dn++;
        end
        chk(strobes == 0, "R9 idle after reset", 32'(strobes), 32'd0);
        chk(dn == 0, "R9 no done after reset", 32'(dn), 32'd0);
    endtask

    initial begin
        while (!finished && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!mem_we && !mem_re && !done, "R9 reset state", 32'({mem_we, mem_re, done}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_we && !mem_re && !done, "R1 idle without start", 32'({mem_we, mem_re, done}), 32'd0);
        // directed corners
        run_seq(16'h8000, 16'h00FF, 8'hA5, 8'h5A, 8'h00, 8'hC0, 8'h10, 0);
        run_seq(16'hFFFF, 16'h0002, 8'h01, 8'h02, 8'hF7, 8'h12, 8'h34, 0); // R2 PC wrap, R3 SP wrap
        run_seq(16'h0100, 16'h0000, 8'hFF, 8'h00, 8'h08, 8'hAB, 8'hCD, 0); // I already set
        run_seq(16'h2000, 16'h01F0, 8'h33, 8'h44, 8'h61, 8'h55, 8'h66, 1); // R7 busy start
        // random
        for (int n = 0; n < 20; n++)
            run_seq(16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 8'($urandom), 8'($urandom), n[0]);
        reset_mid_seq();
        run_seq(16'h4321, 16'h0300, 8'h9A, 8'hBC, 8'h02, 8'hDE, 8'hAD, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule